// File: doc/BRIEF.md
# Clock Source Select Gate Unit

This block holds the control words for a bank of clock outputs. Nine channels share one register bus. Five channels are intermediate integer dividers. Four channels are final outputs: a safe output, a USB output and two general outputs. Each channel has three parts: a source selector, a gate, and, for dividers, a divide ratio. A channel accepts only the source codes on its own allow-list. The divider outputs are fed back as selectable sources, so the channels form a clock tree.

The incoming clocks are modelled as level inputs that are sampled on the system clock, and each one has its own running flag. Every channel switches source through a two-stage handshake. First it gates the old source off while that source is low. Then it enables the new source right after the new source falls. Because of this, no output phase is ever shorter than half a period of the source that was used. The block also reports per channel whether the clock is really running, which means its gate is open and every parent up the tree is running.

Top module: `clksel_gate_unit`

## Requirements
- R1: After reset the dividers read back source code 1 with ratio 0 and disabled. The safe output and the two general outputs read code 1, enabled. The USB output reads code 7, enabled.
- R2: Control word layout: bit 0 is the disable bit (1 = off), bits 28:24 are the 5-bit source code, and the divide field starts at bit 2. The field widths for dividers A through E (channels 0 to 4) are 2, 4, 4, 4 and 8 bits. Upper bits that do not fit the field are dropped on write.
- R3: Divider A (channel 0) accepts codes 0-4 and 6-9. Dividers B through E (channels 1 to 4) accept codes 0-4, 6, 8, 9 and 12 (divider A). A write that carries any other code is ignored in full.
- R4: Writes to the safe output (channel 5) are ignored. It always runs from code 1 and it cannot be gated.
- R5: The USB output (channel 6) accepts only code 7. A write with another code is ignored.
- R6: General output channel 7 accepts codes 0-4, 6, 8, 9 and 12-16. Channel 8 accepts the same codes plus code 7.
- R7: A channel reports running only when its disable bit is clear and its selected source reports running. For a divider source, that in turn needs the divider's own parent chain to be running. Codes 5, 10 and 11 never run.
- R8: A divider with field value N delivers one output clock for every N+1 clocks of its gated input.
- R9: When a channel changes source, every high and low phase of its output lasts at least the shorter half period of the old source and the new source.
- R10: When the disable bit is set, the output stops at low and stays low, and the channel reports not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all source levels |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Channel written (0-4 dividers, 5 safe, 6 USB, 7-8 general) |
| wr_data | input | 32 | Control word to write |
| rd_addr | input | 4 | Channel read back |
| rd_data | output | 32 | Control word of the channel at rd_addr |
| src_lvl | input | 10 | Sampled level of external sources, codes 0 to 9 |
| src_run | input | 10 | Running flag of external sources, codes 0 to 9 |
| clk_out | output | 4 | Gated final outputs, channels 5 to 8 |
| clk_run | output | 4 | Running status of the final outputs |
| div_out | output | 5 | Divider outputs, dividers A to E |
| div_run | output | 5 | Running status of the dividers |

## Verification
The hardest case to reach is a source change that falls at an arbitrary phase of both the old and the new source, because only that exposes a shortened output phase. The stimulus uses two sources with coprime-looking half periods of 8 and 11 cycles. It toggles a general output between them several times with irregular waits, while a monitor records the shortest completed phase. The chain status is reached by selecting divider A into divider E and then divider E into a general output. The test then drops the running flag of the root source, and separately disables the middle link.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int CODE_W    = 5;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int NUM_EXT   = 10;
    localparam int NUM_DIV   = 5;
    localparam int NUM_BASE  = 4;
    localparam int NUM_CH    = NUM_DIV + NUM_BASE;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int DIV_FW    = 8;
    localparam int SEL_LSB   = 24;
    localparam int DIV_LSB   = 2;
    localparam int SAFE_CH   = NUM_DIV;
    localparam int USB_CH    = NUM_DIV + 1;

    localparam logic [CODE_W-1:0] CODE_IRC      = 5'd1;
    localparam logic [CODE_W-1:0] CODE_RSVD     = 5'd5;
    localparam logic [CODE_W-1:0] CODE_USB_PLL  = 5'd7;
    localparam logic [CODE_W-1:0] CODE_DIV_BASE = 5'd12;

    typedef enum logic [2:0] {
        LIST_DIV_FIRST,
        LIST_DIV_LATER,
        LIST_FIXED_IRC,
        LIST_USB,
        LIST_COMMON,
        LIST_ALL
    } list_e;

    typedef struct packed {
        logic              dis;
        logic [CODE_W-1:0] sel;
        logic [DIV_FW-1:0] div;
    } ctl_t;

    typedef struct packed {
        ctl_t [NUM_CH-1:0] ch;
    } regs_t;

    function automatic list_e ch_list(int ch);
        if (ch == 0)            return LIST_DIV_FIRST;
        else if (ch < NUM_DIV)  return LIST_DIV_LATER;
        else if (ch == SAFE_CH) return LIST_FIXED_IRC;
        else if (ch == USB_CH)  return LIST_USB;
        else if (ch == USB_CH + 1) return LIST_COMMON;
        else                    return LIST_ALL;
    endfunction

    function automatic logic code_ok(list_e l, logic [CODE_W-1:0] c);
        logic ext, dv;
        ext = (c < CODE_W'(NUM_EXT)) && (c != CODE_RSVD);
        dv  = (c >= CODE_DIV_BASE) && (c < CODE_DIV_BASE + CODE_W'(NUM_DIV));
        case (l)
            LIST_DIV_FIRST: return ext;
            LIST_DIV_LATER: return (ext && c != CODE_USB_PLL) || (c == CODE_DIV_BASE);
            LIST_FIXED_IRC: return c == CODE_IRC;
            LIST_USB:       return c == CODE_USB_PLL;
            LIST_COMMON:    return (ext && c != CODE_USB_PLL) || dv;
            default:        return ext || dv;
        endcase
    endfunction

    function automatic int div_width(int k);
        case (k)
            0:       return 2;
            4:       return 8;
            default: return 4;
        endcase
    endfunction

    function automatic logic [DIV_FW-1:0] div_mask(int k);
        logic [DIV_FW:0] m;
        m = (9'd1 << div_width(k)) - 9'd1;
        return m[DIV_FW-1:0];
    endfunction

    function automatic logic [CODE_W-1:0] reset_sel(int ch);
        return (ch == USB_CH) ? CODE_USB_PLL : CODE_IRC;
    endfunction

    function automatic regs_t reset_regs();
        regs_t r;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            r.ch[ch].dis = (ch < NUM_DIV);
            r.ch[ch].sel = reset_sel(ch);
            r.ch[ch].div = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/clksel_glitchfree_mux.sv
module clksel_glitchfree_mux
    import clksel_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_SEL = 5'd1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CODES-1:0] lvl,
    input  logic [CODE_W-1:0]    want_sel,
    input  logic                 want_en,
    output logic                 gclk
);

    typedef struct packed {
        logic              on;
        logic [CODE_W-1:0] sel;
        logic              prev;
        logic              g;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.on) begin
            // stage 1: leave the old source only while it is low
            if ((want_sel != st_q.sel || !want_en) && !lvl[st_q.sel]) begin
                st_d.on = 1'b0;
            end
        end else begin
            // stage 2: follow the request, arm on a falling edge of the new source
            st_d.sel  = want_sel;
            st_d.prev = lvl[want_sel];
            if (want_en && want_sel == st_q.sel && st_q.prev && !lvl[st_q.sel]) begin
                st_d.on = 1'b1;
            end
        end
        st_d.g = st_d.on & lvl[st_d.sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{on: 1'b0, sel: RESET_SEL, prev: 1'b0, g: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gclk = st_q.g;

    // R9: the selection moves only while the output is gated off
    a_r9_switch_while_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sel) |-> !$past(st_q.on));

    // R9: the output is re-enabled only at a low level
    a_r9_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.on) |-> !gclk);

    // R10: a disabled, gated-off channel stays low
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!want_en && !st_q.on) |=> !gclk);

endmodule

// File: rtl/clksel_int_div.sv
module clksel_int_div #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gin,
    input  logic [FW-1:0] ratio,
    output logic          dout
);

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          prev;
        logic          o;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = gin;
        if (st_q.prev && !gin) begin
            st_d.cnt = (st_q.cnt >= ratio) ? '0 : st_q.cnt + 1'b1;
        end else if (st_q.cnt > ratio) begin
            st_d.cnt = '0;
        end
        st_d.o = gin && (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.o;

    // R8: every output high follows a high input
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        dout |-> $past(gin));

    // R8: a falling input edge moves the count off its previous value
    a_r8_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.prev) && !$past(gin) && $past(ratio) != '0) |-> !$stable(st_q.cnt));

endmodule

// File: rtl/clksel_gate_unit.sv
module clksel_gate_unit
    import clksel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_EXT-1:0]  src_lvl,
    input  logic [NUM_EXT-1:0]  src_run,
    output logic [NUM_BASE-1:0] clk_out,
    output logic [NUM_BASE-1:0] clk_run,
    output logic [NUM_DIV-1:0]  div_out,
    output logic [NUM_DIV-1:0]  div_run
);

    regs_t regs_d, regs_q;

    logic [CODE_W-1:0]    wr_sel;
    logic [DIV_FW-1:0]    wr_div;
    logic                 wr_dis;
    logic [NUM_CH-1:0]    gate_clk;
    logic [NUM_CODES-1:0] lvl_vec;
    logic                 unused_wr_bits;

    assign wr_sel = wr_data[SEL_LSB +: CODE_W];
    assign wr_div = wr_data[DIV_LSB +: DIV_FW];
    assign wr_dis = wr_data[0];
    assign unused_wr_bits = ^{wr_data[DATA_W-1:SEL_LSB+CODE_W],
                              wr_data[SEL_LSB-1:DIV_LSB+DIV_FW], wr_data[1]};

    // register bank: writes outside a channel's allow-list are dropped
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_addr == ADDR_W'(ch) && ch_list(ch) != LIST_FIXED_IRC
                    && code_ok(ch_list(ch), wr_sel)) begin
                    regs_d.ch[ch].dis = wr_dis;
                    regs_d.ch[ch].sel = wr_sel;
                    regs_d.ch[ch].div = (ch < NUM_DIV) ? (wr_div & div_mask(ch)) : '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= reset_regs();
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_addr == ADDR_W'(ch)) begin
                rd_data[SEL_LSB +: CODE_W] = regs_q.ch[ch].sel;
                rd_data[DIV_LSB +: DIV_FW] = regs_q.ch[ch].div;
                rd_data[0]                 = regs_q.ch[ch].dis;
            end
        end
    end

    // running status, resolved from the roots down the allowed tree
    always_comb begin
        logic [NUM_CODES-1:0] rv;
        rv = '0;
        rv[NUM_EXT-1:0] = src_run;
        rv[CODE_RSVD]   = 1'b0;
        for (int k = 0; k < NUM_DIV; k++) begin
            rv[int'(CODE_DIV_BASE) + k] = !regs_q.ch[k].dis && rv[regs_q.ch[k].sel];
        end
        div_run = rv[int'(CODE_DIV_BASE) +: NUM_DIV];
        for (int b = 0; b < NUM_BASE; b++) begin
            clk_run[b] = !regs_q.ch[NUM_DIV + b].dis && rv[regs_q.ch[NUM_DIV + b].sel];
        end
    end

    always_comb begin
        lvl_vec = '0;
        lvl_vec[NUM_EXT-1:0] = src_lvl;
        lvl_vec[CODE_RSVD]   = 1'b0;
        lvl_vec[int'(CODE_DIV_BASE) +: NUM_DIV] = div_out;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gate
        clksel_glitchfree_mux #(
            .RESET_SEL (reset_sel(ch))
        ) u_mux (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl_vec),
            .want_sel (regs_q.ch[ch].sel),
            .want_en  (!regs_q.ch[ch].dis),
            .gclk     (gate_clk[ch])
        );
    end

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
        localparam int FW = div_width(k);
        clksel_int_div #(
            .FW (FW)
        ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .gin   (gate_clk[k]),
            .ratio (regs_q.ch[k].div[FW-1:0]),
            .dout  (div_out[k])
        );
    end

    assign clk_out = gate_clk[NUM_CH-1:NUM_DIV];

    // R4: a write aimed at the safe channel leaves it untouched
    a_r4_safe_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(SAFE_CH)) |=> $stable(regs_q.ch[SAFE_CH]));

    // R5: the USB channel never leaves its single source
    a_r5_usb_only: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ch[USB_CH].sel == CODE_USB_PLL);

    // R3: the first divider never holds a code outside its list
    a_r3_first_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok(LIST_DIV_FIRST, regs_q.ch[0].sel));

    // R7: a later divider fed by divider A runs only while A runs
    a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (div_run[1] && regs_q.ch[1].sel == CODE_DIV_BASE) |-> div_run[0]);

endmodule

// File: tb/clksel_gate_unit_tb.sv
module clksel_gate_unit_tb;
    import clksel_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic [DATA_W-1:0]   wr_data = '0;
    logic [ADDR_W-1:0]   rd_addr = '0;
    logic [DATA_W-1:0]   rd_data;
    logic [NUM_EXT-1:0]  src_lvl = '0;
    logic [NUM_EXT-1:0]  src_run = '1;
    logic [NUM_BASE-1:0] clk_out;
    logic [NUM_BASE-1:0] clk_run;
    logic [NUM_DIV-1:0]  div_out;
    logic [NUM_DIV-1:0]  div_run;

    clksel_gate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_lvl(src_lvl), .src_run(src_run), .clk_out(clk_out),
        .clk_run(clk_run), .div_out(div_out), .div_run(div_run)
    );

    always #10 clk = ~clk;

    int total = 0;
    int fails = 0;

    // source k has a half period of k+2 cycles
    int half_cnt [NUM_EXT];
    always @(negedge clk) begin
        for (int k = 0; k < NUM_EXT; k++) begin
            half_cnt[k] = half_cnt[k] + 1;
            if (half_cnt[k] >= k + 2) begin
                half_cnt[k] = 0;
                src_lvl[k] = ~src_lvl[k];
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int sel, int dv, int dis);
        return (32'(sel) << 24) | (32'(dv) << 2) | 32'(dis);
    endfunction

    // scoreboard: expected periods queued by the driver, popped by the monitor
    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];
    int   probe_sel = 0;
    logic probe_sig, probe_last = 1'b0;
    int   cyc = 0, last_rise = 0;

    always_comb probe_sig = (probe_sel < NUM_BASE) ? clk_out[probe_sel]
                                                   : div_out[probe_sel - NUM_BASE];

    always @(negedge clk) begin
        cyc++;
        if (probe_sig && !probe_last) begin
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, 32'(cyc - last_rise), 32'(e.val));
            end
            last_rise = cyc;
        end
        probe_last = probe_sig;
    end

    // phase-length monitor on general output channel 8
    logic mon_en = 1'b0, mon_lvl = 1'b0, seg_ok = 1'b0;
    int   run_len = 0, min_run = 1000000, rises = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (clk_out[3] == mon_lvl) run_len++;
            else begin
                if (seg_ok && run_len < min_run) min_run = run_len;
                if (clk_out[3]) rises++;
                seg_ok = 1'b1;
                run_len = 1;
                mon_lvl = clk_out[3];
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, logic [31:0] exp);
        rd_addr = ADDR_W'(a);
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic period(string req, int sel, int p);
        exp_t e;
        probe_sel = sel;
        repeat (3 * p + 40) @(negedge clk);
        e.req = req; e.val = p;
        exp_q.push_back(e);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int k = 0; k < NUM_EXT; k++) half_cnt[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ch < NUM_DIV)     rd_chk("R1", ch, mk(1, 0, 1));
            else if (ch == USB_CH) rd_chk("R1", ch, mk(7, 0, 0));
            else                  rd_chk("R1", ch, mk(1, 0, 0));
        end
        #1 chk("R1 clk_run", 32'(clk_run), 32'hF);
        chk("R1 div_run", 32'(div_run), 32'h0);

        // R4 safe output
        period("R4 safe period", 0, 6);
        wr(SAFE_CH, mk(6, 0, 1));
        rd_chk("R4 write ignored", SAFE_CH, mk(1, 0, 0));
        #1 chk("R4 still running", 32'(clk_run[0]), 32'h1);
        period("R4 safe period after write", 0, 6);

        // R5 USB output
        wr(USB_CH, mk(1, 0, 0));
        rd_chk("R5 foreign code ignored", USB_CH, mk(7, 0, 0));
        period("R5 usb period", 1, 18);

        // R2 / R8 divider A
        wr(0, mk(1, 2, 0));
        rd_chk("R2 layout", 0, mk(1, 2, 0));
        period("R8 div A by 3", 4, 18);
        wr(0, mk(1, 255, 0));
        rd_chk("R2 2-bit field", 0, mk(1, 3, 0));
        period("R8 div A by 4", 4, 24);

        // R3 allow-lists of dividers
        wr(0, mk(12, 1, 0));
        rd_chk("R3 A rejects 12", 0, mk(1, 3, 0));
        wr(0, mk(5, 1, 0));
        rd_chk("R3 A rejects 5", 0, mk(1, 3, 0));
        wr(0, mk(1, 2, 0));
        wr(1, mk(6, 255, 1));
        rd_chk("R2 4-bit field", 1, mk(6, 15, 1));
        wr(1, mk(7, 0, 0));
        rd_chk("R3 B rejects 7", 1, mk(6, 15, 1));
        wr(1, mk(13, 0, 0));
        rd_chk("R3 B rejects 13", 1, mk(6, 15, 1));
        wr(4, mk(12, 1, 0));
        rd_chk("R3 E accepts 12", 4, mk(12, 1, 0));
        period("R8 div E of div A", 8, 36);

        // R6 general outputs
        wr(8, mk(7, 0, 0));
        rd_chk("R6 ch8 accepts 7", 8, mk(7, 0, 0));
        period("R6 ch8 period", 3, 18);
        wr(7, mk(7, 0, 0));
        rd_chk("R6 ch7 rejects 7", 7, mk(1, 0, 0));
        wr(7, mk(16, 0, 0));
        rd_chk("R6 ch7 accepts 16", 7, mk(16, 0, 0));
        period("R6 ch7 from div E", 2, 36);

        // R7 running chain
        #1 chk("R7 chain up", 32'(clk_run[2]), 32'h1);
        @(negedge clk); src_run[1] = 1'b0; #1;
        chk("R7 div A down", 32'(div_run[0]), 32'h0);
        chk("R7 div E down", 32'(div_run[4]), 32'h0);
        chk("R7 ch7 down", 32'(clk_run[2]), 32'h0);
        chk("R7 safe down", 32'(clk_run[0]), 32'h0);
        chk("R7 ch8 unaffected", 32'(clk_run[3]), 32'h1);
        @(negedge clk); src_run[1] = 1'b1;
        wr(0, mk(1, 2, 1));
        #1 chk("R7 gate in chain", 32'(clk_run[2]), 32'h0);
        wr(0, mk(1, 2, 0));
        #1 chk("R7 chain restored", 32'(clk_run[2]), 32'h1);

        // R10 disable
        wr(8, mk(7, 0, 1));
        #1 chk("R10 run flag", 32'(clk_run[3]), 32'h0);
        repeat (40) @(negedge clk);
        begin
            int highs = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (clk_out[3]) highs++;
            end
            chk("R10 output low", 32'(highs), 32'h0);
        end

        // R9 switching between codes 6 and 9 at irregular points
        wr(8, mk(6, 0, 0));
        repeat (60) @(negedge clk);
        mon_en = 1'b1;
        wr(8, mk(9, 0, 0)); repeat (37) @(negedge clk);
        wr(8, mk(6, 0, 0)); repeat (53) @(negedge clk);
        wr(8, mk(9, 0, 0)); repeat (29) @(negedge clk);
        wr(8, mk(6, 0, 0)); repeat (71) @(negedge clk);
        wr(8, mk(9, 0, 0)); repeat (44) @(negedge clk);
        wr(8, mk(6, 0, 0)); repeat (90) @(negedge clk);
        wr(8, mk(9, 0, 0)); repeat (120) @(negedge clk);
        mon_en = 1'b0;
        chk("R9 shortest phase >= 8", 32'(min_run >= 8), 32'h1);
        chk("R9 output toggled", 32'(rises > 5), 32'h1);
        period("R9 settled on code 9", 3, 22);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule